// File: doc/BRIEF.md
# Triple Match-Compare Timer

This peripheral holds three independent counters, each with a host-writable count, a reload value and two compare values. On each counting edge an enabled counter steps by one. A counter that reaches its end value (zero when counting down, all ones when counting up) is loaded from its reload value and keeps running. A reload value of all ones with down counting therefore gives a free-running counter, and a smaller reload value gives a periodic event.

One shared control word holds, for each timer, a run bit, a clock-source bit and an overflow-event enable, plus one direction bit that applies to all timers. A build parameter picks one of two bit packings for this word. A counter either steps on every peripheral clock or only on cycles where the external tick input is high; that input is treated as a synchronous clock-enable. Compare hits and overflows set sticky status bits, which the host clears by writing 1. A single interrupt line is the OR of the status bits whose mask bits are clear.

Top module: `tri_match_timer`

## Requirements
- R1: After reset, every mapped register reads zero, the counters do not move and `irq` is low.
- R2: Register map (word-aligned byte offsets): timer n occupies 0x10*n with count at +0x0, reload at +0x4, compare A at +0x8 and compare B at +0xC. Control is at 0x30, status at 0x34 and mask at 0x38. Every other offset, and every unaligned offset, reads zero and ignores writes.
- R3: A host write to a count register takes effect at that clock edge and wins over counting on the same edge.
- R4: An enabled timer with clock-source bit 0 counts down by one on every clock. Clearing its run bit freezes the value, and setting the bit again resumes counting from the frozen value. The other timers are not affected.
- R5: A down-counting timer at zero loads its reload value on its next counting edge.
- R6: With clock-source bit 1, a timer steps only on clocks where `ext_tick` is high.
- R7: The direction bit (bit 9 in the packed layout, bit 12 in the aligned layout) makes all timers count up. In up mode a timer at all ones loads its reload value on its next counting edge.
- R8: On a counting edge where the current count equals compare A or compare B, status bit 3n or 3n+1 respectively is set for timer n.
- R9: On a counting edge where the end value is reached, status bit 3n+2 is set only if that timer's overflow-event enable is 1.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly when some status bit is set and its mask bit is 0.
- R11: With `ALT_LAYOUT`=0, timer n has its run bit at 3n, clock-source at 3n+1 and overflow enable at 3n+2. With `ALT_LAYOUT`=1 the same fields are at 4n, 4n+1 and 4n+2. Control reads back only the defined bits: 0x3FF for the packed layout and 0x1777 for the aligned layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | Synchronous external count enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The assertions assume that `ext_tick` is already synchronous to `clk` and that `bus_wr` is a clean one-cycle-per-access strobe. They also assume that a status clear and a new hit on the same bit in the same cycle may both happen, so the clear property only checks cycles with no set event. The bench changes its inputs only on falling edges and issues at most one write per cycle. Between writes it waits a known number of edges, so every counting edge is accounted for. Random runs keep the start and reload values below the compare values, so no compare hits interfere with the count being checked.

// File: rtl/tmt_pkg.sv
package tmt_pkg;

   localparam int NTMR  = 3;
   localparam int CTRL_W = 13;
   localparam int STS_W = 3 * NTMR;

   // register select inside a 16-byte bank (address bits 3:2)
   typedef enum logic [1:0] {
      BR_COUNT  = 2'd0,
      BR_RELOAD = 2'd1,
      BR_CMP_A  = 2'd2,
      BR_CMP_B  = 2'd3
   } bank_reg_e;

   // shared registers live in bank index 3
   localparam logic [1:0] SYS_BANK = 2'b11;

   typedef enum logic [1:0] {
      SR_CTRL = 2'd0,
      SR_STS  = 2'd1,
      SR_MASK = 2'd2,
      SR_NONE = 2'd3
   } sys_reg_e;

   function automatic int field_stride(input bit alt);
      return alt ? 4 : 3;
   endfunction

   function automatic int dir_bit(input bit alt);
      return alt ? 12 : 9;
   endfunction

   // bits of the control word that exist in the chosen packing
   function automatic logic [CTRL_W-1:0] ctrl_valid(input bit alt);
      logic [CTRL_W-1:0] m;
      m = '0;
      for (int n = 0; n < NTMR; n++) begin
         for (int f = 0; f < 3; f++) m[field_stride(alt)*n + f] = 1'b1;
      end
      m[dir_bit(alt)] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/tmt_ctrl_map.sv
module tmt_ctrl_map
   import tmt_pkg::*;
#(
   parameter bit ALT_LAYOUT = 1'b0
) (
   input  logic [CTRL_W-1:0] ctrl,
   output logic [NTMR-1:0]   run,
   output logic [NTMR-1:0]   src_ext,
   output logic [NTMR-1:0]   ovf_en,
   output logic              dir_up
);

   localparam int STRIDE = field_stride(ALT_LAYOUT);
   localparam int UP_POS = dir_bit(ALT_LAYOUT);

   generate
      if (STRIDE * (NTMR - 1) + 2 >= CTRL_W || UP_POS >= CTRL_W) begin : g_bad_width
         $error("control word too narrow for layout");
      end
      if (ALT_LAYOUT) begin : g_aligned
         for (genvar n = 0; n < NTMR; n++) begin : g_t
            assign run[n]     = ctrl[4*n];
            assign src_ext[n] = ctrl[4*n+1];
            assign ovf_en[n]  = ctrl[4*n+2];
         end
      end else begin : g_packed
         for (genvar n = 0; n < NTMR; n++) begin : g_t
            assign run[n]     = ctrl[3*n];
            assign src_ext[n] = ctrl[3*n+1];
            assign ovf_en[n]  = ctrl[3*n+2];
         end
      end
   endgenerate

   assign dir_up = ctrl[UP_POS];

endmodule

// File: rtl/tmt_channel.sv
module tmt_channel #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             src_ext,
   input  logic             ext_tick,
   input  logic             dir_up,
   input  logic             ld_cnt,
   input  logic             ld_rld,
   input  logic             ld_cmp_a,
   input  logic             ld_cmp_b,
   input  logic [CNT_W-1:0] wval,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] rld_q,
   output logic [CNT_W-1:0] cmp_a_q,
   output logic [CNT_W-1:0] cmp_b_q,
   output logic             hit_a,
   output logic             hit_b,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] ALL_ONES = '1;
   localparam logic [CNT_W-1:0] ZERO     = '0;

   logic             step;
   logic             at_end;
   logic [CNT_W-1:0] cnt_d;

   assign step   = run & (src_ext ? ext_tick : 1'b1);
   assign at_end = dir_up ? (cnt_q == ALL_ONES) : (cnt_q == ZERO);
   assign wrap   = step & at_end;
   assign hit_a  = step & (cnt_q == cmp_a_q);
   assign hit_b  = step & (cnt_q == cmp_b_q);

   always_comb begin
      cnt_d = cnt_q;
      if (ld_cnt)       cnt_d = wval;
      else if (wrap)    cnt_d = rld_q;
      else if (step)    cnt_d = dir_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         rld_q   <= '0;
         cmp_a_q <= '0;
         cmp_b_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (ld_rld)   rld_q   <= wval;
         if (ld_cmp_a) cmp_a_q <= wval;
         if (ld_cmp_b) cmp_b_q <= wval;
      end
   end

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cnt |=> cnt_q == $past(wval));

   assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_cnt) |=> $stable(cnt_q));

   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !src_ext && !dir_up && cnt_q == ZERO && !ld_cnt) |=> cnt_q == $past(rld_q));

   assert_upwrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !src_ext && dir_up && cnt_q == ALL_ONES && !ld_cnt) |=> cnt_q == $past(rld_q));

   assert_ext_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ext && !ext_tick && !ld_cnt) |=> $stable(cnt_q));

endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer
   import tmt_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter bit ALT_LAYOUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam logic [CTRL_W-1:0] CTRL_VALID = ctrl_valid(ALT_LAYOUT);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and DATA_W");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W must be at least 7");
      end
      if (DATA_W < CTRL_W || DATA_W < STS_W) begin : g_bad_data
         $error("DATA_W too narrow for control or status");
      end
   endgenerate

   // ---------------- address decode ----------------
   logic        aligned, low_page;
   logic [1:0]  bank_idx;
   bank_reg_e   breg;
   sys_reg_e    sreg;
   logic        sys_hit;

   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign low_page = (bus_addr[ADDR_W-1:6] == '0);
   assign bank_idx = bus_addr[5:4];
   assign breg     = bank_reg_e'(bus_addr[3:2]);
   assign sreg     = sys_reg_e'(bus_addr[3:2]);
   assign sys_hit  = aligned && low_page && (bank_idx == SYS_BANK);

   logic wr_ctrl, wr_sts, wr_mask;
   assign wr_ctrl = bus_wr && sys_hit && (sreg == SR_CTRL);
   assign wr_sts  = bus_wr && sys_hit && (sreg == SR_STS);
   assign wr_mask = bus_wr && sys_hit && (sreg == SR_MASK);

   // ---------------- shared registers ----------------
   logic [CTRL_W-1:0] ctrl_q;
   logic [STS_W-1:0]  sts_q, sts_set, sts_clr, mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_VALID;
         if (wr_mask) mask_q <= bus_wdata[STS_W-1:0];
      end
   end

   logic [NTMR-1:0] run, src_ext, ovf_en;
   logic            dir_up;

   tmt_ctrl_map #(.ALT_LAYOUT(ALT_LAYOUT)) u_map (
      .ctrl    (ctrl_q),
      .run     (run),
      .src_ext (src_ext),
      .ovf_en  (ovf_en),
      .dir_up  (dir_up)
   );

   // ---------------- timer channels ----------------
   logic [CNT_W-1:0] cnt_a [NTMR];
   logic [CNT_W-1:0] rld_a [NTMR];
   logic [CNT_W-1:0] cpa_a [NTMR];
   logic [CNT_W-1:0] cpb_a [NTMR];
   logic [NTMR-1:0]  hit_a, hit_b, wrap;

   generate
      for (genvar n = 0; n < NTMR; n++) begin : g_chan
         logic sel;
         assign sel = bus_wr && aligned && low_page && (bank_idx == 2'(n));

         tmt_channel #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run[n]),
            .src_ext  (src_ext[n]),
            .ext_tick (ext_tick),
            .dir_up   (dir_up),
            .ld_cnt   (sel && breg == BR_COUNT),
            .ld_rld   (sel && breg == BR_RELOAD),
            .ld_cmp_a (sel && breg == BR_CMP_A),
            .ld_cmp_b (sel && breg == BR_CMP_B),
            .wval     (bus_wdata[CNT_W-1:0]),
            .cnt_q    (cnt_a[n]),
            .rld_q    (rld_a[n]),
            .cmp_a_q  (cpa_a[n]),
            .cmp_b_q  (cpb_a[n]),
            .hit_a    (hit_a[n]),
            .hit_b    (hit_b[n]),
            .wrap     (wrap[n])
         );

         assign sts_set[3*n]   = hit_a[n];
         assign sts_set[3*n+1] = hit_b[n];
         assign sts_set[3*n+2] = wrap[n] & ovf_en[n];

         assert_ovf_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ovf_en[n]) |=> !$rose(sts_q[3*n+2]));
      end
   endgenerate

   // ---------------- status and interrupt ----------------
   assign sts_clr = wr_sts ? bus_wdata[STS_W-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~sts_clr) | sts_set;
   end

   assign irq = |(sts_q & ~mask_q);

   // ---------------- read path ----------------
   always_comb begin
      bus_rdata = '0;
      if (sys_hit) begin
         case (sreg)
            SR_CTRL: bus_rdata = DATA_W'(ctrl_q);
            SR_STS:  bus_rdata = DATA_W'(sts_q);
            SR_MASK: bus_rdata = DATA_W'(mask_q);
            default: bus_rdata = '0;
         endcase
      end else if (aligned && low_page) begin
         for (int n = 0; n < NTMR; n++) begin
            if (bank_idx == 2'(n)) begin
               case (breg)
                  BR_COUNT:  bus_rdata = DATA_W'(cnt_a[n]);
                  BR_RELOAD: bus_rdata = DATA_W'(rld_a[n]);
                  BR_CMP_A:  bus_rdata = DATA_W'(cpa_a[n]);
                  default:   bus_rdata = DATA_W'(cpb_a[n]);
               endcase
            end
         end
      end
   end

   // ---------------- assertions ----------------
   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && bus_wdata[0] && !sts_set[0]) |=> !sts_q[0]);

   assert_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> !irq);

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[0] && !wr_sts) |=> sts_q[0]);

   assert_ctrl_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~CTRL_VALID) == '0);

endmodule

// File: tb/tri_match_timer_test.sv
`timescale 1ns/10ps
module tri_match_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata, rdata_alt;
   logic        irq, irq_alt;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   always #4 clk = ~clk;

   tri_match_timer uut (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq(irq)
   );

   tri_match_timer #(.ALT_LAYOUT(1'b1)) uut_alt (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_alt), .irq(irq_alt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.1;
      d = rdata;
   endtask

   task automatic rd_alt(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.1;
      d = rdata_alt;
   endtask

   // called just after a falling edge; spans exactly one rising edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] model_down(input logic [31:0] s, input logic [31:0] r, input int n);
      logic [31:0] c = s;
      for (int i = 0; i < n; i++) c = (c == 0) ? r : c - 1;
      return c;
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, v0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 'h3C; a += 4) begin
         rd(8'(a), d);
         chk($sformatf("R1 reset read @%0h", a), d, 32'h0);
      end
      chk("R1 irq low after reset", {31'b0, irq}, 32'h0);
      idle(3);
      rd(8'h00, d);
      chk("R1 counter idle after reset", d, 32'h0);

      // R2: map readback and compare set-up
      wr(8'h14, 32'h1234_5678);
      rd(8'h14, d);
      chk("R2 timer1 reload readback", d, 32'h1234_5678);
      for (int n = 0; n < 3; n++) begin
         wr(8'(16*n + 8), 32'hFFFF_0000);
         wr(8'(16*n + 12), 32'hFFFF_0001);
      end
      rd(8'h2C, d);
      chk("R2 timer2 compare B readback", d, 32'hFFFF_0001);
      wr(8'h34, 32'h1FF);

      // R4: counting, freeze, resume
      wr(8'h00, 32'd10);
      wr(8'h30, 32'h1);
      idle(4);
      rd(8'h00, d);
      chk("R4 down count on clock", d, 32'd6);
      wr(8'h30, 32'h0);
      rd(8'h00, d);
      chk("R4 last step on disable edge", d, 32'd5);
      idle(5);
      rd(8'h00, d);
      chk("R4 frozen while disabled", d, 32'd5);
      wr(8'h30, 32'h1);
      idle(2);
      rd(8'h00, d);
      chk("R4 resume from frozen value", d, 32'd3);

      // R3: host write wins over counting
      wr(8'h00, 32'd50);
      rd(8'h00, d);
      chk("R3 write replaces count", d, 32'd50);
      idle(2);
      rd(8'h00, d);
      chk("R3 count continues from written value", d, 32'd48);

      // R8 / R10: compare hits, mask and clear
      wr(8'h30, 32'h0);
      wr(8'h00, 32'd10);
      wr(8'h08, 32'd3);
      wr(8'h0C, 32'd5);
      wr(8'h34, 32'h1FF);
      wr(8'h30, 32'h1);
      idle(6);
      rd(8'h34, d);
      chk("R8 compare B hit only", d, 32'h2);
      idle(2);
      rd(8'h34, d);
      chk("R8 compare A and B hit", d, 32'h3);
      chk("R10 irq on unmasked status", {31'b0, irq}, 32'h1);
      wr(8'h38, 32'h3);
      chk("R10 irq low when masked", {31'b0, irq}, 32'h0);
      wr(8'h30, 32'h0);
      wr(8'h34, 32'h1);
      rd(8'h34, d);
      chk("R10 write-one clears only that bit", d, 32'h2);
      wr(8'h34, 32'h2);
      rd(8'h34, d);
      chk("R10 status fully cleared", d, 32'h0);
      wr(8'h38, 32'h1);
      wr(8'h08, 32'hFFFF_0000);
      wr(8'h0C, 32'hFFFF_0001);

      // R5 / R9: reload and overflow gating
      wr(8'h00, 32'd2);
      wr(8'h04, 32'd5);
      wr(8'h30, 32'h1);
      idle(4);
      rd(8'h00, d);
      chk("R5 reload after zero", d, 32'd4);
      rd(8'h34, d);
      chk("R9 no overflow status without enable", d, 32'h0);
      wr(8'h30, 32'h0);
      wr(8'h00, 32'd1);
      wr(8'h30, 32'h5);
      idle(3);
      rd(8'h00, d);
      chk("R5 periodic reload", d, 32'd4);
      rd(8'h34, d);
      chk("R9 overflow status with enable", d, 32'h4);
      chk("R10 irq from overflow bit", {31'b0, irq}, 32'h1);
      wr(8'h34, 32'h1FF);
      wr(8'h30, 32'h0);

      // R6 / R11: external tick, and alternate packing of the same word
      wr(8'h10, 32'd100);
      wr(8'h30, 32'h18);
      idle(5);
      rd(8'h10, d);
      chk("R6 no steps without ext_tick", d, 32'd100);
      ext_tick = 1'b1;
      idle(3);
      ext_tick = 1'b0;
      rd(8'h10, d);
      chk("R6 steps on ext_tick cycles", d, 32'd97);
      rd_alt(8'h10, d);
      chk("R11 aligned layout bit4 runs timer1 on clock", d, 32'd92);

      // R7 / R4: up counting, other timer untouched
      wr(8'h30, 32'h0);
      rd(8'h00, v0);
      wr(8'h20, 32'd5);
      wr(8'h30, 32'h240);
      idle(3);
      rd(8'h20, d);
      chk("R7 up count", d, 32'd8);
      rd(8'h00, d);
      chk("R4 timer0 unaffected by timer2", d, v0);
      wr(8'h30, 32'h0);
      wr(8'h24, 32'd7);
      wr(8'h20, 32'hFFFF_FFFE);
      wr(8'h30, 32'h240);
      idle(3);
      rd(8'h20, d);
      chk("R7 all-ones reloads in up mode", d, 32'd8);
      wr(8'h30, 32'h0);
      wr(8'h20, 32'd20);
      wr(8'h30, 32'h1100);
      idle(3);
      rd_alt(8'h20, d);
      chk("R7 aligned layout direction bit12", d, 32'd23);
      rd(8'h20, d);
      chk("R11 packed layout bit8 is not a run bit", d, 32'd20);

      // R11: control readback masks
      wr(8'h30, 32'hFFFF_FFFF);
      rd(8'h30, d);
      chk("R11 packed control readback", d, 32'h3FF);
      rd_alt(8'h30, d);
      chk("R11 aligned control readback", d, 32'h1777);
      wr(8'h30, 32'h0);

      // R2: unmapped and unaligned
      wr(8'h3C, 32'hDEAD_BEEF);
      rd(8'h3C, d);
      chk("R2 unmapped 0x3C reads zero", d, 32'h0);
      rd(8'h40, d);
      chk("R2 unmapped 0x40 reads zero", d, 32'h0);
      wr(8'h15, 32'hAAAA_AAAA);
      rd(8'h14, d);
      chk("R2 unaligned write ignored", d, 32'h1234_5678);

      // R4 / R5: random start, reload and run length
      for (int it = 0; it < 24; it++) begin
         logic [31:0] s, r;
         int n;
         s = $urandom_range(0, 40);
         r = $urandom_range(0, 20);
         n = $urandom_range(1, 60);
         wr(8'h30, 32'h0);
         wr(8'h00, s);
         wr(8'h04, r);
         wr(8'h30, 32'h1);
         idle(n);
         rd(8'h00, d);
         chk($sformatf("R5 random run s=%0d r=%0d n=%0d", s, r, n), d, model_down(s, r, n));
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule